// File: doc/BRIEF.md
# Bit-Serial Unsigned Magnitude Comparator

This block decides which of two unsigned words is larger. It uses a single one-bit compare cell for all bit positions, one position per clock cycle. A pulse on `start` captures both operands into local registers. A small controller then walks a bit index from the least significant position to the most significant one. On each step it passes the selected bit pair and the registered running flags through the cell and writes the result back into the flags.

When the last position has been handled, the final flags are copied to the `g` and `l` outputs and `done` pulses for one cycle. The outputs keep their values until the next accepted `start`. A higher-order differing bit always overrides whatever the lower positions decided. For this reason the serial order from bit 0 upward gives the same answer as a full parallel compare.

Top module: `serial_mag_cmp`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle with `g`, `l` and `done` all low, even if `start` is high.
- R2: After a comparison, `g` is high exactly when the captured A is greater than the captured B, both read as unsigned.
- R3: After a comparison, `l` is high exactly when the captured A is less than the captured B, both read as unsigned.
- R4: Equal operands leave `g` and `l` both low, and `g` and `l` are never high in the same cycle.
- R5: `done` is high for exactly one cycle, following the fourth rising edge after the edge that samples `start` in idle (WIDTH=4). No other cycle has `done` high.
- R6: `start` is accepted only while idle. A `start` raised during the bit steps, or in the cycle `done` is high, is ignored. That run's operands, result and `done` timing are unchanged, and no second `done` follows.
- R7: An accepted `start` clears `g` and `l` on the next edge. After `done`, `g` and `l` hold the result until the next accepted `start`.
- R8: The most significant differing bit decides the result whatever the lower bits are. For example, A=4'b1000 against B=4'b0111 gives `g` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Requests a comparison of `a` and `b`; sampled only while idle |
| a | input | WIDTH (4) | Unsigned operand A |
| b | input | WIDTH (4) | Unsigned operand B |
| g | output | 1 | A greater than B |
| l | output | 1 | A less than B |
| done | output | 1 | One-cycle pulse when the result becomes valid |

## Verification
Every one of the 256 operand pairs is compared in turn. This covers equal pairs, pairs that differ only in bit 0, and pairs where the top bit disagrees against every lower-bit pattern, which separates correct most-significant-bit priority from a result that follows the last bit processed. Some runs raise `start` again with the operands swapped, once during the bit steps and once in the `done` cycle. A design that accepts such a late request reports the reversed answer or an extra `done`. The `done` cycle is checked against the start edge, and the outputs are checked for holding after `done` and clearing on a new start.

// File: rtl/smc_pkg.sv
// Package: smc_pkg
// Shared types for the bit-serial magnitude comparator.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package smc_pkg;

    // Controller states: waiting, stepping through bits, presenting result.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctl_state_t;

endpackage : smc_pkg

// File: rtl/smc_bit_cell.sv
// Module: smc_bit_cell
// One-bit magnitude compare cell. It folds a bit pair into incoming
// greater/less flags that summarise less significant positions.
// A differing bit here overrides the incoming flags; equal bits pass them on.
// Assumes: the incoming flags are never both high.
module smc_bit_cell (
    input  logic a_bit,
    input  logic b_bit,
    input  logic gt_in,
    input  logic lt_in,
    output logic gt_out,
    output logic lt_out
);

    logic same;

    // Combine the local bit decision with the incoming running flags.
    always_comb begin
        same   = ~(a_bit ^ b_bit);
        gt_out = (a_bit & ~b_bit) | (same & gt_in);
        lt_out = (~a_bit & b_bit) | (same & lt_in);
    end

endmodule : smc_bit_cell

// File: rtl/smc_datapath.sv
// Module: smc_datapath
// Operand registers, running flags, bit index and result registers
// around one shared smc_bit_cell.
// Assumes: load, step and finish come from smc_ctrl; finish only with step.
module smc_datapath #(
    parameter int WIDTH = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             finish,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic             last_bit,
    output logic             res_g,
    output logic             res_l
);

    logic [WIDTH-1:0] op_a;
    logic [WIDTH-1:0] op_b;
    logic [IDX_W-1:0] idx;
    logic             flag_g;
    logic             flag_l;
    logic             cell_g;
    logic             cell_l;
    logic             sel_a;
    logic             sel_b;

    // Select the current bit pair for the shared cell.
    always_comb begin
        sel_a    = op_a[idx];
        sel_b    = op_b[idx];
        last_bit = (idx == IDX_W'(WIDTH - 1));
    end

    smc_bit_cell u_cell (
        .a_bit  (sel_a),
        .b_bit  (sel_b),
        .gt_in  (flag_g),
        .lt_in  (flag_l),
        .gt_out (cell_g),
        .lt_out (cell_l)
    );

    // Capture operands on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_a <= '0;
            op_b <= '0;
        end else if (load) begin
            op_a <= a_in;
            op_b <= b_in;
        end
    end

    // Running flags and bit index: cleared on load, advanced on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            flag_g <= 1'b0;
            flag_l <= 1'b0;
            idx    <= '0;
        end else if (step) begin
            flag_g <= cell_g;
            flag_l <= cell_l;
            idx    <= idx + 1'b1;
        end
    end

    // Result registers: cleared on load, written on the final step, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            res_g <= 1'b0;
            res_l <= 1'b0;
        end else if (finish) begin
            res_g <= cell_g;
            res_l <= cell_l;
        end
    end

    // R4: the running flags never claim both orders.
    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_g && flag_l));

    // R6: operands stay put once stepping has begun.
    a_r6_operands_hold: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ($stable(op_a) && $stable(op_b)));

    // R2: the written greater result matches an unsigned compare of the operands.
    a_r2_result_gt: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (res_g == (op_a > op_b)));

    // R3: the written less result matches an unsigned compare of the operands.
    a_r3_result_lt: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (res_l == (op_a < op_b)));

endmodule : smc_datapath

// File: rtl/smc_ctrl.sv
// Module: smc_ctrl
// Three-state controller for the serial compare. It accepts start only
// when idle, steps once per cycle until the last bit, then shows done
// for one cycle.
// Assumes: last_bit reflects the index of the bit being stepped this cycle.
module smc_ctrl
    import smc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic last_bit,
    output logic load,
    output logic step,
    output logic finish,
    output logic done
);

    ctl_state_t state;
    ctl_state_t state_nx;

    // Decode the datapath controls and the next state.
    always_comb begin
        load     = (state == ST_IDLE) && start;
        step     = (state == ST_RUN);
        finish   = step && last_bit;
        done     = (state == ST_DONE);
        state_nx = state;
        case (state)
            ST_IDLE: if (start)    state_nx = ST_RUN;
            ST_RUN:  if (last_bit) state_nx = ST_DONE;
            ST_DONE:               state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R5: done never lasts two cycles.
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: done only follows the final step.
    a_r5_done_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(finish));

    // R6: a start during the bit steps does not disturb the run.
    a_r6_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && start && !last_bit) |=> (state == ST_RUN));

endmodule : smc_ctrl

// File: rtl/serial_mag_cmp.sv
// Module: serial_mag_cmp (top)
// Bit-serial unsigned magnitude comparator. One compare cell is reused
// for WIDTH cycles under smc_ctrl, and the result is held until the next start.
// Assumes: synchronous active-low reset; start sampled on rising edges.
module serial_mag_cmp #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             g,
    output logic             l,
    output logic             done
);

    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    logic load;
    logic step;
    logic finish;
    logic last_bit;

    smc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .last_bit (last_bit),
        .load     (load),
        .step     (step),
        .finish   (finish),
        .done     (done)
    );

    smc_datapath #(
        .WIDTH (WIDTH),
        .IDX_W (IDX_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .finish   (finish),
        .a_in     (a),
        .b_in     (b),
        .last_bit (last_bit),
        .res_g    (g),
        .res_l    (l)
    );

    // R4: the outputs never report both orders at once.
    a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(g && l));

    // R7: outputs only change at load or at the final step.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !finish) |=> ($stable(g) && $stable(l)));

endmodule : serial_mag_cmp

// File: tb/tb_serial_mag_cmp.sv
// Scoreboard bench: the driver pushes expected {g,l} at each start, and the
// monitor pops one entry per done and compares it with the outputs.
module tb_serial_mag_cmp;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] a = '0;
    logic [3:0] b = '0;
    logic       g;
    logic       l;
    logic       done;

    int         n_chk = 0;
    int         n_fail = 0;
    logic [1:0] exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    serial_mag_cmp #(.WIDTH(4)) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .a     (a),
        .b     (b),
        .g     (g),
        .l     (l),
        .done  (done)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare each done against the oldest expected result (R2 R3 R4 R8).
    always @(negedge clk) begin
        if (rst_n && done === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk("R5 unexpected done", 8'd1, 8'd0);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                chk("R2/R3/R4/R8 result {g,l}", {6'd0, g, l}, {6'd0, e});
            end
        end
    end

    // Driver: mode 0 plain, 1 late start during steps, 2 late start in done cycle.
    task automatic run_vec(input logic [3:0] va, input logic [3:0] vb, input int mode);
        logic [1:0] e;
        e = {va > vb, va < vb};
        @(negedge clk);
        a = va; b = vb; start = 1'b1;
        exp_q.push_back(e);
        @(negedge clk);
        start = 1'b0; a = ~va; b = ~vb;
        chk("R7 cleared on start", {6'd0, g, l}, 8'd0);
        chk("R5 no early done", {7'd0, done}, 8'd0);
        @(negedge clk);
        if (mode == 1) begin start = 1'b1; a = vb; b = va; end
        chk("R5 no early done", {7'd0, done}, 8'd0);
        @(negedge clk);
        start = 1'b0;
        chk("R5 no early done", {7'd0, done}, 8'd0);
        @(negedge clk);
        chk("R5 no early done", {7'd0, done}, 8'd0);
        @(negedge clk);
        chk("R5 done on fourth edge", {7'd0, done}, 8'd1);
        if (mode == 2) begin start = 1'b1; a = vb; b = va; end
        @(negedge clk);
        start = 1'b0;
        chk("R5 done one cycle", {7'd0, done}, 8'd0);
        chk("R7 hold after done", {6'd0, g, l}, {6'd0, e});
        if (mode != 0) begin
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                chk("R6 late start ignored: no done", {7'd0, done}, 8'd0);
                chk("R6 late start ignored: result", {6'd0, g, l}, {6'd0, e});
            end
        end
    endtask

    initial begin
        // R1: reset with start asserted.
        start = 1'b1; a = 4'hF; b = 4'h0;
        repeat (3) @(negedge clk);
        chk("R1 reset g", {7'd0, g}, 8'd0);
        chk("R1 reset l", {7'd0, l}, 8'd0);
        chk("R1 reset done", {7'd0, done}, 8'd0);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {5'd0, g, l, done}, 8'd0);

        // R8 corner cases, then all pairs.
        run_vec(4'b1000, 4'b0111, 0);
        run_vec(4'b0111, 4'b1000, 0);
        run_vec(4'b0001, 4'b0000, 0);
        run_vec(4'b1010, 4'b1010, 0);
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                run_vec(4'(i), 4'(j), 0);
            end
        end
        // R6: late starts with swapped operands.
        run_vec(4'b1100, 4'b0011, 1);
        run_vec(4'b0010, 4'b1001, 2);
        run_vec(4'b0101, 4'b0101, 1);

        repeat (4) @(negedge clk);
        chk("R5 every start gave one done", 8'(exp_q.size()), 8'd0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule : tb_serial_mag_cmp